// File: doc/BRIEF.md
# DMA Channel Enable and Request Mask Bank

This block keeps two bits of control state for every channel of a multi-channel DMA controller. One bit is a request mask and the other is a channel enable. Software never changes either bit with a read-modify-write. Instead, each bit vector has a pair of register addresses: writing a 1 to a bit at the "set" address sets that channel's bit, and writing a 1 at the "clear" address clears it. Zeros written to either address leave the state alone. The set addresses also read back the current vector. The clear addresses are write-only and read as zero.

The block uses this state to gate the raw peripheral request lines. A channel's request reaches the DMA engine only when the peripheral asks, the channel is enabled and the channel is not masked. When the engine finishes a channel's transfer, it sends a one-cycle completion pulse for that channel, and the pulse drops the channel's enable bit in hardware. Software therefore has to re-arm each channel for every transfer. The channel count is a parameter. Register bits above that count are discarded on write and read back as zero.

Top module: `dma_chan_gate`

## Requirements
- R1: After a synchronous active-low reset, every mask bit and every enable bit is 0, all readable addresses return 0, and every `chan_req` bit is 0.
- R2: A write to byte offset 0x0 (mask-set) sets the mask bit of each channel whose data bit is 1 and leaves the other mask bits unchanged. A read of offset 0x0 returns the mask vector in bits [NUM_CH-1:0]. Each update appears on the clock edge that samples the write.
- R3: A write to offset 0x4 (mask-clear) clears the mask bit of each channel whose data bit is 1 and leaves the other mask bits unchanged.
- R4: A write to offset 0x8 (enable-set) sets the enable bit of each channel whose data bit is 1 and leaves the other enable bits unchanged. A read of offset 0x8 returns the enable vector.
- R5: A write to offset 0xC (enable-clear) clears the enable bit of each channel whose data bit is 1 and leaves the other enable bits unchanged.
- R6: A high `xfer_done[i]` at a clock edge clears enable bit i at that edge.
- R7: When an enable-set for channel i arrives in the same cycle as a completion pulse for channel i, the enable bit ends up 0.
- R8: Reads of offsets 0x4 and 0xC, and of any offset other than 0x0 and 0x8, return 0. Writes to offsets other than the four listed above change nothing.
- R9: Write-data bits at positions NUM_CH and above are discarded. Read-data bits at positions NUM_CH and above are always 0.
- R10: `chan_req[i]` is high in the same cycle exactly when `periph_req[i]` is 1, mask bit i is 0 and enable bit i is 1.
- R11: While `bus_wr` is low, the mask and enable bits do not change. The only exception is clearing by completion pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| periph_req | input | NUM_CH | Raw DMA request per channel from peripherals |
| xfer_done | input | NUM_CH | Transfer-complete pulse per channel |
| chan_req | output | NUM_CH | Gated request per channel toward the DMA engine |

## Verification
The embedded properties assume that every input is driven to a known value while reset is released, and that the address and write strobe are sampled as one access per clock. They make no assumption about how completion pulses line up with writes. The bench drives all inputs just after each rising edge and holds them until the next one. It mixes directed accesses with a long random run. In that run, completion pulses, peripheral requests, unmapped addresses and write strobes collide freely, so the clear-over-set ordering is exercised many times.

// File: rtl/dmagate_pkg.sv
// Package: shared offsets and types for the DMA channel gate bank.
// Assumes byte addressing with 32-bit registers at word-aligned offsets.
package dmagate_pkg;
    localparam int REG_W        = 32;
    localparam int OFS_MASK_SET = 0;
    localparam int OFS_MASK_CLR = 4;
    localparam int OFS_EN_SET   = 8;
    localparam int OFS_EN_CLR   = 12;

    // One decoded write strobe per alias address
    typedef struct packed {
        logic mask_set;
        logic mask_clr;
        logic en_set;
        logic en_clr;
    } wr_hit_t;

    // Which state vector a read returns
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_MASK = 2'd1,
        RSEL_EN   = 2'd2
    } rd_sel_t;
endpackage

// File: rtl/dmagate_decode.sv
// Module: dmagate_decode
// Turns the register-bus address and write strobe into one-hot write strobes,
// one per alias, and a read selector. Unmapped offsets produce no strobe and
// select nothing. Assumes the address is a byte offset that fits in ADDR_W bits.
module dmagate_decode
    import dmagate_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    output wr_hit_t           hit,
    output rd_sel_t           rsel
);
    logic at_mask_set;
    logic at_mask_clr;
    logic at_en_set;
    logic at_en_clr;

    // Compare the address against each alias offset
    always_comb begin
        at_mask_set = (bus_addr == ADDR_W'(OFS_MASK_SET));
        at_mask_clr = (bus_addr == ADDR_W'(OFS_MASK_CLR));
        at_en_set   = (bus_addr == ADDR_W'(OFS_EN_SET));
        at_en_clr   = (bus_addr == ADDR_W'(OFS_EN_CLR));
    end

    // Qualify the matches with the write strobe
    always_comb begin
        hit.mask_set = bus_wr & at_mask_set;
        hit.mask_clr = bus_wr & at_mask_clr;
        hit.en_set   = bus_wr & at_en_set;
        hit.en_clr   = bus_wr & at_en_clr;
    end

    // Only the set aliases read back state; the clear aliases read zero
    always_comb begin
        if (at_mask_set)    rsel = RSEL_MASK;
        else if (at_en_set) rsel = RSEL_EN;
        else                rsel = RSEL_NONE;
    end
endmodule

// File: rtl/dmagate_chan.sv
// Module: dmagate_chan
// Holds the mask and enable bits of one channel and gates its request.
// The write strobes and the data bit arrive already decoded. A completion pulse
// or an enable-clear beats an enable-set in the same cycle. Reset is synchronous
// and active low.
module dmagate_chan
    import dmagate_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wr_hit_t hit,
    input  logic    wbit,
    input  logic    done,
    input  logic    preq,
    output logic    mask_q,
    output logic    en_q,
    output logic    req
);
    logic mask_set_go;
    logic mask_clr_go;
    logic en_set_go;
    logic en_drop;

    // Per-channel write intent: the strobe counts only with a 1 data bit
    always_comb begin
        mask_set_go = hit.mask_set & wbit;
        mask_clr_go = hit.mask_clr & wbit;
        en_set_go   = hit.en_set & wbit;
        en_drop     = (hit.en_clr & wbit) | done;
    end

    // Mask bit: set and clear come from different addresses, so they never meet
    always_ff @(posedge clk) begin
        if (!rst_n)           mask_q <= 1'b0;
        else if (mask_set_go) mask_q <= 1'b1;
        else if (mask_clr_go) mask_q <= 1'b0;
    end

    // Enable bit: any clearing cause wins over a set
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= 1'b0;
        else if (en_drop)   en_q <= 1'b0;
        else if (en_set_go) en_q <= 1'b1;
    end

    // Gated request toward the engine
    always_comb req = preq & en_q & ~mask_q;

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !en_q); // R6
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.en_set && wbit && done) |=> !en_q); // R7
    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.en_set && wbit && !done) |=> en_q); // R4
    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.en_clr && wbit) |=> !en_q); // R5
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.mask_set && wbit) |=> mask_q); // R2
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (hit.mask_clr && wbit) |=> !mask_q); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0 && !done) |=> ($stable(en_q) && $stable(mask_q))); // R11
endmodule

// File: rtl/dmagate_rdmux.sv
// Module: dmagate_rdmux
// Chooses the read-back vector and zero-extends it to the register width.
// Assumes NUM_CH is at most the register width.
module dmagate_rdmux
    import dmagate_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  rd_sel_t           rsel,
    input  logic [NUM_CH-1:0] mask_vec,
    input  logic [NUM_CH-1:0] en_vec,
    output logic [REG_W-1:0]  rdata
);
    // Zero-extended selection of the state vector
    always_comb begin
        rdata = '0;
        case (rsel)
            RSEL_MASK: rdata[NUM_CH-1:0] = mask_vec;
            RSEL_EN:   rdata[NUM_CH-1:0] = en_vec;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_chan_gate.sv
// Module: dma_chan_gate
// Top of the per-channel mask/enable bank. The bank is reached through
// write-1-set and write-1-clear aliases on a simple synchronous register bus,
// and it gates the peripheral requests. Assumes 1 <= NUM_CH <= 32 and one
// access per clock. Reads are combinational from the stored state.
module dma_chan_gate
    import dmagate_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] periph_req,
    input  logic [NUM_CH-1:0] xfer_done,
    output logic [NUM_CH-1:0] chan_req
);
    localparam int SPARE_W = REG_W - NUM_CH;

    wr_hit_t           hit;
    rd_sel_t           rsel;
    logic [NUM_CH-1:0] mask_vec;
    logic [NUM_CH-1:0] en_vec;

    initial begin
        if (NUM_CH < 1 || NUM_CH > REG_W)
            $error("dma_chan_gate: NUM_CH out of range");
    end

    dmagate_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .hit      (hit),
        .rsel     (rsel)
    );

    // One state cell per implemented channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        dmagate_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit),
            .wbit   (bus_wdata[ch]),
            .done   (xfer_done[ch]),
            .preq   (periph_req[ch]),
            .mask_q (mask_vec[ch]),
            .en_q   (en_vec[ch]),
            .req    (chan_req[ch])
        );
    end

    // Write-data bits above the channel count are deliberately discarded
    if (SPARE_W > 0) begin : g_spare
        logic unused_wdata_hi;
        assign unused_wdata_hi = ^bus_wdata[REG_W-1:NUM_CH];

        AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            bus_rdata[REG_W-1:NUM_CH] == '0); // R9
    end

    dmagate_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
        .rsel     (rsel),
        .mask_vec (mask_vec),
        .en_vec   (en_vec),
        .rdata    (bus_rdata)
    );

    AST_REQ_NEEDS_PERIPH: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req & ~periph_req) == '0); // R10
    AST_RD_CLEAR_ALIAS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_MASK_CLR) || bus_addr == ADDR_W'(OFS_EN_CLR))
            |-> bus_rdata == '0); // R8
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (chan_req == '0)); // R1
endmodule

// File: tb/dma_chan_gate_bench.sv
// Bench: behavioural reference model updated on every clock and compared
// with both outputs in every cycle.
module dma_chan_gate_bench;
    localparam int NCH = 8;
    localparam int AW  = 4;
    localparam bit [31:0] IMPL = (NCH == 32) ? 32'hFFFF_FFFF : ((32'd1 << NCH) - 32'd1);

    logic           clk = 1'b0;
    logic           rst_n;
    logic [AW-1:0]  bus_addr;
    logic           bus_wr;
    logic [31:0]    bus_wdata;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] periph_req;
    logic [NCH-1:0] xfer_done;
    logic [NCH-1:0] chan_req;

    int checks = 0;
    int errors = 0;
    bit [31:0] m_mask = '0;
    bit [31:0] m_en   = '0;

    always #4 clk = ~clk;  // 125 MHz

    dma_chan_gate #(.NUM_CH(NCH), .ADDR_W(AW)) u_dma_chan_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .periph_req (periph_req),
        .xfer_done  (xfer_done),
        .chan_req   (chan_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive, compare outputs mid-cycle, then advance the model
    task automatic cycle(input logic [AW-1:0] a, input logic w, input logic [31:0] d,
                         input logic [NCH-1:0] pr, input logic [NCH-1:0] dn,
                         input string tag);
        logic [31:0] exp_rd;
        logic [31:0] exp_req;
        bus_addr = a; bus_wr = w; bus_wdata = d; periph_req = pr; xfer_done = dn;
        #1;
        if (a == 4'd0)      exp_rd = m_mask;
        else if (a == 4'd8) exp_rd = m_en;
        else                exp_rd = '0;
        exp_req = 32'(pr) & ~m_mask & m_en & IMPL;
        check(tag, bus_rdata, exp_rd);
        check("R10", 32'(chan_req), exp_req);
        @(posedge clk);
        if (!rst_n) begin
            m_mask = '0;
            m_en   = '0;
        end else begin
            if (w) begin
                case (a)
                    4'd0:  m_mask = m_mask | (d & IMPL);
                    4'd4:  m_mask = m_mask & ~d;
                    4'd8:  m_en   = m_en | (d & IMPL);
                    4'd12: m_en   = m_en & ~d;
                    default: ;
                endcase
            end
            m_en = m_en & ~32'(dn);
        end
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; periph_req = '0; xfer_done = '0;
        @(posedge clk); #1;
        cycle(4'd0, 1'b0, 32'h0, '0, '0, "R1");
        cycle(4'd0, 1'b0, 32'h0, '0, '0, "R1");
        rst_n = 1'b1;
        // R1: reset state through both readable aliases and the request outputs
        cycle(4'd0, 1'b0, 32'h0, '1, '0, "R1");
        cycle(4'd8, 1'b0, 32'h0, '1, '0, "R1");
        // R9: all 32 enable bits written; only NCH survive
        cycle(4'd8, 1'b1, 32'hFFFF_FFFF, '0, '0, "R4");
        cycle(4'd8, 1'b0, 32'h0, '1, '0, "R9");
        // R2: mask channels 0 and 2; a zero write then changes nothing
        cycle(4'd0, 1'b1, 32'h0000_0005, '1, '0, "R2");
        cycle(4'd0, 1'b0, 32'h0, '1, '0, "R2");
        cycle(4'd0, 1'b1, 32'h0, '1, '0, "R2");
        cycle(4'd0, 1'b0, 32'h0, 8'hA5, '0, "R2");
        // R3: unmask channel 0; the clear alias reads zero (R8)
        cycle(4'd4, 1'b1, 32'h0000_0001, '1, '0, "R8");
        cycle(4'd0, 1'b0, 32'h0, '1, '0, "R3");
        // R5: disable channels 0 and 1
        cycle(4'd12, 1'b1, 32'h0000_0003, '1, '0, "R8");
        cycle(4'd8, 1'b0, 32'h0, '1, '0, "R5");
        // R6: completion on channel 7
        cycle(4'd8, 1'b0, 32'h0, '1, 8'h80, "R6");
        cycle(4'd8, 1'b0, 32'h0, '1, '0, "R6");
        // R7: enable-set and completion on channel 7 together
        cycle(4'd8, 1'b1, 32'h0000_0080, '1, 8'h80, "R7");
        cycle(4'd8, 1'b0, 32'h0, '1, '0, "R7");
        // R11: strobe low with enable-set address and data present
        cycle(4'd8, 1'b0, 32'hFFFF_FFFF, '1, '0, "R11");
        cycle(4'd8, 1'b0, 32'h0, '1, '0, "R11");
        // R8: write to an unmapped offset, then read it and both state aliases
        cycle(4'd2, 1'b1, 32'hFFFF_FFFF, '1, '0, "R8");
        cycle(4'd2, 1'b0, 32'h0, '1, '0, "R8");
        cycle(4'd0, 1'b0, 32'h0, '1, '0, "R8");
        cycle(4'd8, 1'b0, 32'h0, '1, '0, "R8");
        // R1: reset in mid-run clears the state again
        rst_n = 1'b0;
        cycle(4'd0, 1'b0, 32'h0, '1, '0, "R1");
        rst_n = 1'b1;
        cycle(4'd0, 1'b0, 32'h0, '1, '0, "R1");
        cycle(4'd8, 1'b0, 32'h0, '1, '0, "R1");
        // Random traffic with colliding writes, completions and requests
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] a;
            string tg;
            case ($urandom_range(0, 4))
                0: a = 4'd0;
                1: a = 4'd4;
                2: a = 4'd8;
                3: a = 4'd12;
                default: a = AW'($urandom_range(0, 15));
            endcase
            if (a == 4'd0)      tg = "R2";
            else if (a == 4'd8) tg = "R4";
            else                tg = "R8";
            cycle(a, 1'($urandom_range(0, 1)), $urandom(),
                  NCH'($urandom()), NCH'($urandom() & $urandom()), tg);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule